// File: doc/BRIEF.md
# Eight-Stage Operand Bypass Selector

This block chooses where each ALU operand comes from for the instruction about to enter the execute stage of an eight-stage in-order integer pipeline. It compares the two source register numbers of that consumer with the destination registers of the four instructions further down the pipe. Those four are held, youngest first, in the registers after execute, after the first data-cache stage, after the second data-cache stage and after tag check. For each operand it produces a select code that drives the operand mux in front of the ALU.

Load results only exist once the second data-cache stage has finished. A load that matches from one of the two younger holding registers therefore cannot be bypassed. In that case the block raises a not-ready flag for the operand, and the stall logic outside the block acts on that flag. The second ALU input is bypassed only when the consumer is a register-register ALU operation. For every other class that input keeps its normal path. The block is purely combinational and has no clock or reset.

Top module: `bypass_select_unit`

## Requirements
- R1: When no producer matches a source register, that operand's select is 0 (register file value) and its not-ready flag is 0.
- R2: A register-register ALU producer (class 0) or an ALU-immediate producer (class 1) is forwarded from any holding register. Select code 1 is the post-execute register (`prod_*` slot 0), 2 is slot 1, 3 is slot 2 and 4 is slot 3 (the deepest).
- R3: A load producer (class 2) is forwarded only from slot 2 or slot 3, giving select code 3 or 4.
- R4: When the chosen producer is a load in slot 0 or slot 1, the select is 0 and the operand's not-ready flag is 1.
- R5: When several slots match, the lowest-numbered (youngest) slot decides the outcome. This holds even when the youngest match is a load that is not yet available.
- R6: A producer with write-enable low, or with destination register 0, never matches.
- R7: Operand A is bypassed for every consumer class. The consumer class encodings are: 0 register-register ALU, 1 ALU-immediate, 2 load, 3 store, 4 branch.
- R8: Operand B is bypassed only when the consumer class is 0. For any other class, `sel_b` is 0 and `notready_b` is 0.
- R9: A producer of class 3 (writes no register result) never matches.
- R10: The two operands are resolved independently. When both source registers name the same register, both operands receive the same outcome (provided R8 allows operand B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cons_rs1 | input | RW | First source register of the consumer |
| cons_rs2 | input | RW | Second source register of the consumer |
| cons_class | input | 3 | Consumer class (0 rr-ALU, 1 ALU-imm, 2 load, 3 store, 4 branch) |
| prod_dst | input | NSRC*RW | Producer destinations, slot k at bits [k*RW +: RW], slot 0 youngest |
| prod_we | input | NSRC | Producer write-enables, bit k is slot k |
| prod_class | input | NSRC*2 | Producer classes (0 rr-ALU, 1 ALU-imm, 2 load, 3 none), slot k at [2k +: 2] |
| sel_a | output | SEL_W | Operand A source: 0 register file, k+1 slot k |
| sel_b | output | SEL_W | Operand B source, same coding |
| notready_a | output | 1 | Operand A depends on a load whose data is not yet available |
| notready_b | output | 1 | Operand B depends on a load whose data is not yet available |

## Verification
The block holds no state, so any faulty internal decision shows up on `sel_*` or `notready_*` in the same evaluation as the inputs that trigger it. A broken per-slot comparator shows up as a missing or extra select code for that one slot. A wrong priority walk shows up only when two or more slots match at once. A wrong load-availability bound appears as a load being selected from slot 0 or 1, or as a not-ready flag raised against slot 2. For these reasons the directed tests place single matches in each slot, overlap matches in pairs, and then run a pseudo-random sweep against a model that walks the slots oldest-first.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [1:0] {
    PC_RR   = 2'd0,
    PC_IMM  = 2'd1,
    PC_LOAD = 2'd2,
    PC_NONE = 2'd3
  } prod_cls_e;

  typedef enum logic [2:0] {
    CC_RR     = 3'd0,
    CC_IMM    = 3'd1,
    CC_LOAD   = 3'd2,
    CC_STORE  = 3'd3,
    CC_BRANCH = 3'd4
  } cons_cls_e;

  // A producer slot can supply data when it writes a real register.
  function automatic logic slot_writes(input logic we, input logic is_zero_dst,
                                       input logic [1:0] cls);
    return we && !is_zero_dst && (cls != PC_NONE);
  endfunction

  // Load data exists only in slots at or beyond the ready depth.
  function automatic logic load_too_young(input logic [1:0] cls, input int slot,
                                          input int ready_idx);
    return (cls == PC_LOAD) && (slot < ready_idx);
  endfunction
endpackage

// File: rtl/bsu_src_match.sv
module bsu_src_match
  import bsu_pkg::*;
#(
  parameter int RW        = 5,
  parameter int SLOT      = 0,
  parameter int READY_IDX = 2
) (
  input  logic [RW-1:0] src_reg,
  input  logic [RW-1:0] dst_reg,
  input  logic          we,
  input  logic [1:0]    cls,
  output logic          hit,
  output logic          early
);
  logic dst_zero;
  logic same_reg;

  assign dst_zero = (dst_reg == '0);
  assign same_reg = (dst_reg == src_reg);
  assign hit      = slot_writes(we, dst_zero, cls) && same_reg;
  assign early    = hit && load_too_young(cls, SLOT, READY_IDX);
endmodule

// File: rtl/bsu_prio_pick.sv
module bsu_prio_pick #(
  parameter int NSRC  = 4,
  parameter int SEL_W = 3
) (
  input  logic [NSRC-1:0]  hit,
  input  logic [NSRC-1:0]  early,
  input  logic             enable,
  output logic [SEL_W-1:0] sel,
  output logic             notready
);
  logic found;

  always_comb begin
    sel      = '0;
    notready = 1'b0;
    found    = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (!found && hit[i]) begin
        found = 1'b1;
        if (early[i]) notready = 1'b1;
        else          sel      = SEL_W'(i + 1);
      end
    end
    if (!enable) begin
      sel      = '0;
      notready = 1'b0;
    end
  end
endmodule

// File: rtl/bypass_select_unit.sv
module bypass_select_unit
  import bsu_pkg::*;
#(
  parameter int RW        = 5,
  parameter int NSRC      = 4,
  parameter int READY_IDX = 2,
  parameter int SEL_W     = $clog2(NSRC + 1)
) (
  input  logic [RW-1:0]      cons_rs1,
  input  logic [RW-1:0]      cons_rs2,
  input  logic [2:0]         cons_class,
  input  logic [NSRC*RW-1:0] prod_dst,
  input  logic [NSRC-1:0]    prod_we,
  input  logic [NSRC*2-1:0]  prod_class,
  output logic [SEL_W-1:0]   sel_a,
  output logic [SEL_W-1:0]   sel_b,
  output logic               notready_a,
  output logic               notready_b
);
  logic [NSRC-1:0] hit_a, hit_b;
  logic [NSRC-1:0] early_a, early_b;
  logic            b_bypass_ok;

  assign b_bypass_ok = (cons_class == CC_RR);

  for (genvar k = 0; k < NSRC; k++) begin : g_slot
    bsu_src_match #(.RW(RW), .SLOT(k), .READY_IDX(READY_IDX)) u_cmp_a (
      .src_reg (cons_rs1),
      .dst_reg (prod_dst[k*RW +: RW]),
      .we      (prod_we[k]),
      .cls     (prod_class[k*2 +: 2]),
      .hit     (hit_a[k]),
      .early   (early_a[k])
    );
    bsu_src_match #(.RW(RW), .SLOT(k), .READY_IDX(READY_IDX)) u_cmp_b (
      .src_reg (cons_rs2),
      .dst_reg (prod_dst[k*RW +: RW]),
      .we      (prod_we[k]),
      .cls     (prod_class[k*2 +: 2]),
      .hit     (hit_b[k]),
      .early   (early_b[k])
    );
  end

  bsu_prio_pick #(.NSRC(NSRC), .SEL_W(SEL_W)) u_pick_a (
    .hit      (hit_a),
    .early    (early_a),
    .enable   (1'b1),
    .sel      (sel_a),
    .notready (notready_a)
  );

  bsu_prio_pick #(.NSRC(NSRC), .SEL_W(SEL_W)) u_pick_b (
    .hit      (hit_b),
    .early    (early_b),
    .enable   (b_bypass_ok),
    .sel      (sel_b),
    .notready (notready_b)
  );
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker
  import bsu_pkg::*;
#(
  parameter int RW        = 5,
  parameter int NSRC      = 4,
  parameter int READY_IDX = 2,
  parameter int SEL_W     = 3
) (
  input logic [RW-1:0]      cons_rs1,
  input logic [2:0]         cons_class,
  input logic [NSRC*RW-1:0] prod_dst,
  input logic [NSRC-1:0]    prod_we,
  input logic [NSRC*2-1:0]  prod_class,
  input logic [NSRC-1:0]    hit_a,
  input logic [SEL_W-1:0]   sel_a,
  input logic [SEL_W-1:0]   sel_b,
  input logic               notready_a,
  input logic               notready_b
);
  int          idx;
  logic [1:0]  pcls;
  logic [RW-1:0] pdst;
  logic        pwe;
  logic        younger_hit;

  always_comb begin
    idx         = 0;
    younger_hit = 1'b0;
    if (sel_a != '0 && int'(sel_a) <= NSRC) idx = int'(sel_a) - 1;
    pcls = prod_class[idx*2 +: 2];
    pdst = prod_dst[idx*RW +: RW];
    pwe  = prod_we[idx];
    for (int j = 0; j < NSRC; j++)
      if (j < idx && hit_a[j]) younger_hit = 1'b1;

    AST_SEL_IN_RANGE: assert (int'(sel_a) <= NSRC && int'(sel_b) <= NSRC); // R2
    AST_NOTREADY_EXCL: assert (!(notready_a && sel_a != '0)); // R4
    if (sel_a != '0) begin
      AST_SEL_REAL_PRODUCER: assert (pwe && pdst != '0 && pdst == cons_rs1); // R6
      AST_SEL_HAS_RESULT: assert (pcls != PC_NONE); // R9
      AST_LOAD_DEPTH_OK: assert (!(pcls == PC_LOAD && idx < READY_IDX)); // R3
      AST_YOUNGEST_WINS: assert (!younger_hit); // R5
    end
    if (cons_class != CC_RR) begin
      AST_B_HELD_OFF: assert (sel_b == '0 && !notready_b); // R8
    end
  end
endmodule

bind bypass_select_unit bsu_checker #(
  .RW(RW), .NSRC(NSRC), .READY_IDX(READY_IDX), .SEL_W(SEL_W)
) u_chk (
  .cons_rs1   (cons_rs1),
  .cons_class (cons_class),
  .prod_dst   (prod_dst),
  .prod_we    (prod_we),
  .prod_class (prod_class),
  .hit_a      (hit_a),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .notready_a (notready_a),
  .notready_b (notready_b)
);

// File: tb/bypass_select_unit_tb.sv
module bypass_select_unit_tb;
  localparam int RW = 5;
  localparam int NS = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [RW-1:0]    cons_rs1, cons_rs2;
  logic [2:0]       cons_class;
  logic [NS*RW-1:0] prod_dst;
  logic [NS-1:0]    prod_we;
  logic [NS*2-1:0]  prod_class;
  logic [SW-1:0]    sel_a, sel_b;
  logic             notready_a, notready_b;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  bypass_select_unit u_dut (
    .cons_rs1(cons_rs1), .cons_rs2(cons_rs2), .cons_class(cons_class),
    .prod_dst(prod_dst), .prod_we(prod_we), .prod_class(prod_class),
    .sel_a(sel_a), .sel_b(sel_b), .notready_a(notready_a), .notready_b(notready_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prod();
    prod_dst = '0; prod_we = '0; prod_class = {NS{2'd3}};
  endtask

  task automatic set_slot(input int k, input int dst, input bit we, input int cls);
    prod_dst[k*RW +: RW] = RW'(dst);
    prod_we[k]           = we;
    prod_class[k*2 +: 2] = 2'(cls);
  endtask

  // Model: walk oldest to youngest so the youngest valid match is left standing.
  function automatic int model(input int rs, input bit opb);
    int sel = 0; int nr = 0;
    for (int k = NS - 1; k >= 0; k--) begin
      int d = int'(prod_dst[k*RW +: RW]);
      int c = int'(prod_class[k*2 +: 2]);
      if (prod_we[k] && d != 0 && d == rs && c != 3) begin
        if (c == 2 && k < 2) begin sel = 0; nr = 1; end
        else begin sel = k + 1; nr = 0; end
      end
    end
    if (opb && cons_class != 3'd0) begin sel = 0; nr = 0; end
    return nr * 8 + sel;
  endfunction

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic t_idle();
    cons_rs1 = 5'd0; cons_rs2 = 5'd0; cons_class = 3'd0; clear_prod();
    settle();
    chk("R1 idle sel_a", int'(sel_a), 0);
    chk("R1 idle sel_b", int'(sel_b), 0);
    chk("R1 idle nr_a", int'(notready_a), 0);
    cons_rs1 = 5'd7; cons_rs2 = 5'd9; set_slot(1, 12, 1, 0);
    settle();
    chk("R1 unrelated dst sel_a", int'(sel_a), 0);
    chk("R1 unrelated dst sel_b", int'(sel_b), 0);
  endtask

  task automatic t_each_source();
    for (int k = 0; k < NS; k++) begin
      for (int c = 0; c < 2; c++) begin
        clear_prod(); cons_class = 3'd0; cons_rs1 = 5'd4; cons_rs2 = 5'd5;
        set_slot(k, 4, 1, c); set_slot((k + 1) % NS, 5, 1, c);
        settle();
        chk("R2 sel_a slot code", int'(sel_a), k + 1);
        chk("R2 sel_b slot code", int'(sel_b), ((k + 1) % NS) + 1);
      end
    end
  endtask

  task automatic t_load_depth();
    for (int k = 0; k < NS; k++) begin
      clear_prod(); cons_class = 3'd0; cons_rs1 = 5'd3; cons_rs2 = 5'd3;
      set_slot(k, 3, 1, 2);
      settle();
      if (k >= 2) begin
        chk("R3 load bypass sel_a", int'(sel_a), k + 1);
        chk("R3 load bypass nr_a", int'(notready_a), 0);
      end else begin
        chk("R4 young load sel_a", int'(sel_a), 0);
        chk("R4 young load nr_a", int'(notready_a), 1);
        chk("R4 young load nr_b", int'(notready_b), 1);
      end
    end
  endtask

  task automatic t_priority();
    clear_prod(); cons_class = 3'd0; cons_rs1 = 5'd8; cons_rs2 = 5'd0;
    set_slot(1, 8, 1, 0); set_slot(3, 8, 1, 1);
    settle();
    chk("R5 slot1 over slot3", int'(sel_a), 2);
    set_slot(0, 8, 1, 2);
    settle();
    chk("R5 young load over older alu sel", int'(sel_a), 0);
    chk("R5 young load over older alu nr", int'(notready_a), 1);
    clear_prod(); set_slot(0, 8, 1, 1); set_slot(1, 8, 1, 2);
    settle();
    chk("R5 alu shadows load sel", int'(sel_a), 1);
    chk("R5 alu shadows load nr", int'(notready_a), 0);
    clear_prod(); set_slot(2, 8, 1, 2); set_slot(3, 8, 1, 0);
    settle();
    chk("R5 slot2 load over slot3", int'(sel_a), 3);
  endtask

  task automatic t_gating();
    clear_prod(); cons_class = 3'd0; cons_rs1 = 5'd6; cons_rs2 = 5'd0;
    set_slot(0, 6, 0, 0); set_slot(2, 6, 1, 1);
    settle();
    chk("R6 we low skipped", int'(sel_a), 3);
    clear_prod(); cons_rs1 = 5'd0; cons_rs2 = 5'd0;
    set_slot(0, 0, 1, 0); set_slot(1, 0, 1, 2);
    settle();
    chk("R6 r0 sel_a", int'(sel_a), 0);
    chk("R6 r0 nr_a", int'(notready_a), 0);
    clear_prod(); cons_rs1 = 5'd6; set_slot(0, 6, 1, 3); set_slot(3, 6, 1, 0);
    settle();
    chk("R9 class none skipped", int'(sel_a), 4);
  endtask

  task automatic t_consumer_classes();
    for (int cc = 0; cc < 5; cc++) begin
      clear_prod(); cons_class = 3'(cc); cons_rs1 = 5'd10; cons_rs2 = 5'd11;
      set_slot(1, 10, 1, 0); set_slot(2, 11, 1, 1);
      settle();
      chk("R7 operand A all classes", int'(sel_a), 2);
      chk("R8 operand B class gate", int'(sel_b), (cc == 0) ? 3 : 0);
      clear_prod(); set_slot(0, 11, 1, 2);
      settle();
      chk("R8 operand B notready gate", int'(notready_b), (cc == 0) ? 1 : 0);
    end
  endtask

  task automatic t_both_same();
    clear_prod(); cons_class = 3'd0; cons_rs1 = 5'd13; cons_rs2 = 5'd13;
    set_slot(2, 13, 1, 0); set_slot(3, 14, 1, 0);
    settle();
    chk("R10 same reg sel_a", int'(sel_a), 3);
    chk("R10 same reg sel_b", int'(sel_b), 3);
    cons_rs2 = 5'd14;
    settle();
    chk("R10 independent sel_b", int'(sel_b), 4);
  endtask

  task automatic t_sweep();
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cons_rs1   = RW'(lfsr[2:0]);
      cons_rs2   = RW'(lfsr[5:3]);
      cons_class = (lfsr[6]) ? 3'd0 : 3'(lfsr[9:7] % 5);
      for (int k = 0; k < NS; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        set_slot(k, int'(lfsr[2:0]), lfsr[3], int'(lfsr[5:4]));
      end
      settle();
      chk("R5 sweep operand A", int'(notready_a) * 8 + int'(sel_a), model(int'(cons_rs1), 0));
      chk("R8 sweep operand B", int'(notready_b) * 8 + int'(sel_b), model(int'(cons_rs2), 1));
    end
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cons_rs1 = '0; cons_rs2 = '0; cons_class = '0; clear_prod();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_each_source();
    t_load_depth();
    t_priority();
    t_gating();
    t_consumer_classes();
    t_both_same();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule